// File: doc/BRIEF.md
# Prioritized Window Partition Decoder

This block takes a 64-bit outbound address and matches it against sixteen programmable address windows. For the address it returns the partition number that owns it, taken from the highest-priority window that contains it. The address is not translated; it comes out unchanged beside the result. Software, or a configuration engine, loads each window through a simple write port. A window is described by an enable bit, a base address, a log2 size, a segmented-mode flag and a fixed partition number.

A window can be unsegmented or segmented. An unsegmented window maps every address inside it to its fixed partition number. A segmented window is cut into 256 equal slices, and the slice index is the partition number; there is no lookup table in between. Windows may overlap. When they do, the window with the lowest index wins. A window narrower than 256 MB is treated as unusable, and so is a disabled window.

Lookups are pipelined. One request is accepted every cycle, and each result appears two cycles after its request.

Top module: `wdec_part_decoder`

## Requirements
- R1: A write with `cfg_we` high loads all fields of window `cfg_win` at that clock edge. Requests sampled at any later edge are decoded with the new settings.
- R2: `res_addr` equals the `req_addr` of the request the result belongs to (no translation).
- R3: An address that hits an unsegmented window (`cfg_seg`=0) gets that window's `cfg_part` value on `res_part`.
- R4: An address that hits a segmented window (`cfg_seg`=1) with log2 size S gets `res_part` = address bits [S-1:S-8], the segment index 0..255.
- R5: When several usable windows contain the address, `res_win` reports the lowest index among them, and `res_part` follows that window.
- R6: When no usable window contains the address, `res_hit`=0, `res_win`=0 and `res_part`=0.
- R7: A request sampled with `req_valid`=1 produces `res_valid`=1 exactly two clock edges later. Back-to-back requests are accepted on every cycle.
- R8: A window that is disabled, or whose log2 size is below 28 (256 MB), never hits.
- R9: Window i contains address A when A[63:S] equals base[63:S], where S is the log2 size. Base bits below S are ignored, which gives natural alignment.
- R10: Reset disables all windows and clears `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_win | input | 4 | Index of window being written |
| cfg_en | input | 1 | Window enable |
| cfg_seg | input | 1 | 1 = segmented mode |
| cfg_size | input | 6 | log2 of window size in bytes |
| cfg_base | input | 64 | Window base address |
| cfg_part | input | 8 | Partition number for unsegmented mode |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | Address to decode |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Address fell in a usable window |
| res_win | output | 4 | Index of the winning window |
| res_part | output | 8 | Partition number |
| res_addr | output | 64 | Untranslated address |

## Verification
Several properties are checked on every cycle by the assertions: a register write lands in the addressed window, the valid bit moves through both pipeline stages, a disabled or undersized window never raises its match bit, and a miss reports zero. The winner is also checked on every cycle to be the lowest set bit of the match vector. Only the bench's sweeps can show that the partition numbers are correct: the segment slice taken from the right address bits, base low bits ignored, behaviour exactly at window edges, and reprogramming taking effect. The sweeps cover overlapping segmented and unsegmented windows before and after reprogramming, and compare against an arithmetic model.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
   localparam int ADDR_W   = 64;
   localparam int SIZE_W   = 6;
   localparam int PART_W   = 8;
   localparam int SEG_W    = 8;
   localparam int MIN_LOG2 = 28;

   typedef struct packed {
      logic              en;
      logic              seg;
      logic [SIZE_W-1:0] size;
      logic [ADDR_W-1:0] base;
      logic [PART_W-1:0] part;
   } win_cfg_t;
endpackage

// File: rtl/wdec_cfg_bank.sv
module wdec_cfg_bank
   import wdec_pkg::*;
#(
   parameter int NUM_WIN = 16,
   localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  win_cfg_t                 wdata_i,
   output win_cfg_t [NUM_WIN-1:0]   cfg_o
);
   win_cfg_t [NUM_WIN-1:0] cfg_q;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[g] <= '0;
         end else if (we_i && (idx_i == IDX_W'(g))) begin
            cfg_q[g] <= wdata_i;
         end
      end

      // R1
      cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we_i && (idx_i == IDX_W'(g))) |=> (cfg_q[g] == $past(wdata_i)));

      // R1
      cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(we_i && (idx_i == IDX_W'(g))) |=> $stable(cfg_q[g]));
   end

   assign cfg_o = cfg_q;
endmodule

// File: rtl/wdec_win_match.sv
module wdec_win_match
   import wdec_pkg::*;
#(
   parameter int MIN_SIZE_LOG2 = MIN_LOG2
) (
   input  win_cfg_t          cfg_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [PART_W-1:0] part_o
);
   logic [ADDR_W-1:0] keep_mask;
   logic [SIZE_W-1:0] seg_shift;
   logic [ADDR_W-1:0] shifted;
   logic              usable;

   always_comb begin
      usable    = cfg_i.en && (cfg_i.size >= SIZE_W'(MIN_SIZE_LOG2));
      keep_mask = {ADDR_W{1'b1}} << cfg_i.size;
      hit_o     = usable && (((addr_i ^ cfg_i.base) & keep_mask) == '0);
      seg_shift = cfg_i.size - SIZE_W'(SEG_W);
      shifted   = addr_i >> seg_shift;
      part_o    = cfg_i.seg ? shifted[PART_W-1:0] : cfg_i.part;
   end
endmodule

// File: rtl/wdec_prio_pick.sv
module wdec_prio_pick
   import wdec_pkg::*;
#(
   parameter int NUM_WIN = 16,
   localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [NUM_WIN-1:0]             hit_vec,
   input  logic [NUM_WIN-1:0][PART_W-1:0] part_vec,
   input  logic [ADDR_W-1:0]              in_addr,
   output logic                           out_valid,
   output logic                           out_hit,
   output logic [IDX_W-1:0]               out_win,
   output logic [PART_W-1:0]              out_part,
   output logic [ADDR_W-1:0]              out_addr
);
   logic              sel_any;
   logic [IDX_W-1:0]  sel_idx;
   logic [PART_W-1:0] sel_part;

   always_comb begin
      sel_any  = 1'b0;
      sel_idx  = '0;
      sel_part = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            sel_any  = 1'b1;
            sel_idx  = IDX_W'(i);
            sel_part = part_vec[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_win   <= '0;
         out_part  <= '0;
         out_addr  <= '0;
      end else begin
         out_valid <= in_valid;
         out_hit   <= in_valid && sel_any;
         out_win   <= sel_any ? sel_idx : '0;
         out_part  <= sel_any ? sel_part : '0;
         out_addr  <= in_addr;
      end
   end

   // R5
   lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> ($past(hit_vec)[out_win] &&
                   (($past(hit_vec) & ((NUM_WIN'(1) << out_win) - NUM_WIN'(1))) == '0)));

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (hit_vec == '0)) |=> (!out_hit && out_part == '0 && out_win == '0));
endmodule

// File: rtl/wdec_part_decoder.sv
module wdec_part_decoder
   import wdec_pkg::*;
#(
   parameter int NUM_WIN       = 16,
   parameter int A_W           = ADDR_W,
   parameter int P_W           = PART_W,
   parameter int MIN_SIZE_LOG2 = MIN_LOG2,
   localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_win,
   input  logic              cfg_en,
   input  logic              cfg_seg,
   input  logic [SIZE_W-1:0] cfg_size,
   input  logic [A_W-1:0]    cfg_base,
   input  logic [P_W-1:0]    cfg_part,
   input  logic              req_valid,
   input  logic [A_W-1:0]    req_addr,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_win,
   output logic [P_W-1:0]    res_part,
   output logic [A_W-1:0]    res_addr
);
   if (A_W != ADDR_W) begin : g_bad_addr_w
      $error("A_W must match package address width");
   end
   if (P_W != SEG_W) begin : g_bad_part_w
      $error("partition width must equal segment index width");
   end
   if (MIN_SIZE_LOG2 < SEG_W || MIN_SIZE_LOG2 >= A_W) begin : g_bad_min
      $error("minimum window size out of range");
   end
   if (NUM_WIN < 1) begin : g_bad_num
      $error("need at least one window");
   end

   win_cfg_t                        wdata;
   win_cfg_t [NUM_WIN-1:0]          cfg;
   logic [NUM_WIN-1:0]              hit_c;
   logic [NUM_WIN-1:0][P_W-1:0]     part_c;
   logic                            s1_valid;
   logic [NUM_WIN-1:0]              s1_hit;
   logic [NUM_WIN-1:0][P_W-1:0]     s1_part;
   logic [A_W-1:0]                  s1_addr;

   assign wdata = '{en: cfg_en, seg: cfg_seg, size: cfg_size,
                    base: cfg_base, part: cfg_part};

   wdec_cfg_bank #(.NUM_WIN(NUM_WIN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .idx_i   (cfg_win),
      .wdata_i (wdata),
      .cfg_o   (cfg)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
      wdec_win_match #(.MIN_SIZE_LOG2(MIN_SIZE_LOG2)) u_match (
         .cfg_i  (cfg[g]),
         .addr_i (req_addr),
         .hit_o  (hit_c[g]),
         .part_o (part_c[g])
      );

      // R8
      unusable_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg[g].en || (cfg[g].size < SIZE_W'(MIN_SIZE_LOG2))) |=> !s1_hit[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= '0;
         s1_part  <= '0;
         s1_addr  <= '0;
      end else begin
         s1_valid <= req_valid;
         s1_hit   <= req_valid ? hit_c : '0;
         s1_part  <= part_c;
         s1_addr  <= req_addr;
      end
   end

   wdec_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s1_valid),
      .hit_vec   (s1_hit),
      .part_vec  (s1_part),
      .in_addr   (s1_addr),
      .out_valid (res_valid),
      .out_hit   (res_hit),
      .out_win   (res_win),
      .out_part  (res_part),
      .out_addr  (res_addr)
   );

   // R7
   stage1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> s1_valid);

   // R7
   stage2_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> res_valid);

   // R7
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !res_valid);

   // R2
   addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> (res_addr == $past(s1_addr)));
endmodule

// File: tb/wdec_part_decoder_tb.sv
module wdec_part_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_win = '0;
   logic        cfg_en = 1'b0;
   logic        cfg_seg = 1'b0;
   logic [5:0]  cfg_size = '0;
   logic [63:0] cfg_base = '0;
   logic [7:0]  cfg_part = '0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        res_valid, res_hit;
   logic [3:0]  res_win;
   logic [7:0]  res_part;
   logic [63:0] res_addr;

   always #2.5 clk = ~clk;

   wdec_part_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
      .cfg_en(cfg_en), .cfg_seg(cfg_seg), .cfg_size(cfg_size),
      .cfg_base(cfg_base), .cfg_part(cfg_part), .req_valid(req_valid),
      .req_addr(req_addr), .res_valid(res_valid), .res_hit(res_hit),
      .res_win(res_win), .res_part(res_part), .res_addr(res_addr)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // model of the programmed windows
   bit          m_en   [16];
   bit          m_seg  [16];
   int          m_size [16];
   logic [63:0] m_base [16];
   logic [7:0]  m_part [16];

   // expected results, indexed by request number
   bit          e_hit  [4096];
   int          e_win  [4096];
   logic [7:0]  e_part [4096];
   logic [63:0] e_addr [4096];
   string       e_tag  [4096];
   int          e_cyc  [4096];
   int wr_ptr = 0;
   int rd_ptr = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model(input logic [63:0] a, output bit hit, output int win,
                        output logic [7:0] part, output int nhits, output bit shadow);
      hit = 0; win = 0; part = 0; nhits = 0; shadow = 0;
      for (int i = 0; i < 16; i++) begin
         logic [63:0] mask;
         mask = ~64'd0 << m_size[i];
         if (((a ^ m_base[i]) & mask) == 64'd0) begin
            if (m_en[i] && m_size[i] >= 28) begin
               nhits++;
               if (!hit) begin
                  hit = 1; win = i;
                  part = m_seg[i] ? 8'((a >> (m_size[i] - 8)) & 64'hFF) : m_part[i];
               end
            end else if (!hit && (m_en[i] || m_size[i] != 0 || m_base[i] != 0)) begin
               shadow = 1;
            end
         end
      end
   endtask

   task automatic wr(input int idx, input bit en, input bit seg, input int size,
                     input logic [63:0] base, input logic [7:0] part);
      @(negedge clk);
      cfg_we = 1; cfg_win = 4'(idx); cfg_en = en; cfg_seg = seg;
      cfg_size = 6'(size); cfg_base = base; cfg_part = part;
      m_en[idx] = en; m_seg[idx] = seg; m_size[idx] = size;
      m_base[idx] = base; m_part[idx] = part;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic issue(input logic [63:0] a, input string force_tag);
      bit h, sh; int w, n; logic [7:0] p;
      model(a, h, w, p, n, sh);
      @(negedge clk);
      req_valid = 1; req_addr = a;
      e_hit[wr_ptr] = h; e_win[wr_ptr] = w; e_part[wr_ptr] = p;
      e_addr[wr_ptr] = a; e_cyc[wr_ptr] = cyc;
      if (force_tag != "")  e_tag[wr_ptr] = force_tag;
      else if (sh)          e_tag[wr_ptr] = "R8";
      else if (!h)          e_tag[wr_ptr] = "R6";
      else if (n > 1)       e_tag[wr_ptr] = "R5";
      else if (m_seg[w])    e_tag[wr_ptr] = "R4";
      else                  e_tag[wr_ptr] = "R3";
      wr_ptr++;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 0;
   endtask

   // result monitor
   always @(negedge clk) begin
      if (rst_n && res_valid && !done) begin
         if (rd_ptr >= wr_ptr) begin
            chk(0, "R7", "unexpected result", 64'(rd_ptr), 64'(wr_ptr));
         end else begin
            chk(res_hit == e_hit[rd_ptr], e_tag[rd_ptr], "hit", 64'(res_hit), 64'(e_hit[rd_ptr]));
            chk(res_win == 4'(e_win[rd_ptr]), e_tag[rd_ptr], "win", 64'(res_win), 64'(e_win[rd_ptr]));
            chk(res_part == e_part[rd_ptr], e_tag[rd_ptr], "part", 64'(res_part), 64'(e_part[rd_ptr]));
            chk(res_addr == e_addr[rd_ptr], "R2", "addr", res_addr, e_addr[rd_ptr]);
            chk(cyc - e_cyc[rd_ptr] == 2, "R7", "latency", 64'(cyc - e_cyc[rd_ptr]), 64'd2);
            rd_ptr++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, 200000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_en[i] = 0; m_seg[i] = 0; m_size[i] = 0; m_base[i] = 0; m_part[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(res_valid == 0, "R10", "res_valid in reset", 64'(res_valid), 64'd0);
      rst_n = 1;
      @(negedge clk);
      chk(res_valid == 0, "R10", "res_valid after reset", 64'(res_valid), 64'd0);

      // R10: all windows disabled after reset, every lookup misses
      issue(64'h0, "R10");
      issue(64'h1_0000_0000, "R10");
      issue(64'hFFFF_FFFF_FFFF_FFFF, "R10");
      issue(64'h1_2345_6789, "R10");
      idle();
      repeat (4) @(negedge clk);

      // phase B configuration
      wr(0, 1, 0, 27, 64'h1_0000_0000, 8'h11);        // too small: R8
      wr(1, 1, 1, 28, 64'h1_2000_1234, 8'h22);        // segmented, junk low base bits: R9
      wr(3, 1, 0, 32, 64'h1_0000_0000, 8'h5A);        // unsegmented 4 GB
      wr(7, 0, 0, 40, 64'h0, 8'h77);                  // disabled
      for (int k = 0; k < 600; k++) issue(64'hF000_0000 + 64'(k) * 64'h80_0000, "");
      // R9 boundary addresses around window 1
      issue(64'h1_2000_0000, "R9");
      issue(64'h1_2FFF_FFFF, "R9");
      issue(64'h1_3000_0000, "R9");
      issue(64'h1_1FFF_FFFF, "R9");
      issue(64'h1_27F0_0000, "R4");
      idle();
      repeat (4) @(negedge clk);

      // phase C: reprogram, R1
      wr(3, 1, 1, 32, 64'h1_0000_0000, 8'h5A);
      wr(1, 0, 1, 28, 64'h1_2000_0000, 8'h22);
      wr(15, 1, 0, 40, 64'h0, 8'hEE);
      issue(64'h1_2300_0000, "R1");
      issue(64'h1_A500_0000, "R1");
      for (int k = 0; k < 600; k++) issue(64'hF000_0000 + 64'(k) * 64'h80_0000, "");
      issue(64'h100_0000_0000, "R6");
      issue(64'hFF_FFFF_FFFF, "R3");
      issue(64'h1_FFFF_FFFF, "R4");
      idle();
      repeat (6) @(negedge clk);
      chk(rd_ptr == wr_ptr, "R7", "results drained", 64'(rd_ptr), 64'(wr_ptr));
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule